// File: doc/BRIEF.md
# Value-Prediction Dependence Resolver

This block lets a ten-stage in-order pipeline run through register flow dependences without ever stalling or forwarding. The pipeline is modelled here only as a chain of tag and valid registers: one Fetch slot at the block's input, then two Decode stages, five Execute stages, a Memory stage and Writeback. When an instruction sits in the second Decode stage, each of its two source registers is compared with the destinations of the older instructions in Execute 1 through Memory. On a hit, the block hands the instruction a guessed operand and records that guess against the producing instruction.

The guess comes from a last-value table with one entry per architectural register. Writeback refreshes the table with every result. When a register-writing instruction reaches Writeback, its real result (driven by the surrounding pipeline on `wbResult`) is compared with every recorded guess made for it. Any wrong guess empties the whole pipeline and the log. In the next cycle the block raises `flushReq` together with the PC of the oldest instruction that consumed a wrong value, and fetch restarts there. A taken branch in Execute 5 squashes the younger stages and drops the guesses those younger instructions had made.

Top module: `vp_resolver`

## Requirements
- R1: After reset no stage holds an instruction, `flushReq` is low, both hit flags are low and every entry of the last-value table reads zero.
- R2: `predHitA` (`predHitB`) is high in a cycle exactly when the second Decode stage holds a valid instruction whose source A (B) is nonzero and equals the destination of a valid instruction in Execute 1 through Memory.
- R3: While the second Decode stage is valid, `predValA`/`predValB` equal the value last written at Writeback to that source register, or zero if none was written. A Writeback in the same cycle does not yet show.
- R4: When several in-flight instructions write the same register, a guess is tied to the youngest of them, the one nearest the consumer.
- R5: If a Writeback instruction with a nonzero destination has a result that differs from any live guess tied to it, then all stages and all logged guesses are discarded at that clock edge. The fetch offered in that cycle is dropped, and `flushReq` is high in the following cycle only.
- R6: With `flushReq`, `restartPc` holds the PC of the oldest consumer whose guess was wrong, even when several guesses fail at the same Writeback.
- R7: `branchTaken` with a valid instruction in Execute 5 drops the fetch input and the instructions in Decode 1 through Execute 4. It also discards the guesses of every consumer younger than the branch, and those guesses are not checked even at a Writeback in the same cycle.
- R8: Register 0 never produces a dependence, whether it is read as a source or named as a destination.
- R9: Guesses that match the real result cause no flush. Several guesses for one register, from different instructions, may be in flight together.
- R10: A Writeback that triggers a flush still updates the last-value table with its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | An instruction is offered at Fetch this cycle |
| fetchPc | input | PCW | PC of the offered instruction |
| fetchDst | input | RW | Destination register, 0 means no write |
| fetchSrcA | input | RW | First source register |
| fetchSrcB | input | RW | Second source register |
| branchTaken | input | 1 | The instruction in Execute 5 is a taken branch |
| wbResult | input | DW | Real result of the instruction in Writeback |
| predHitA | output | 1 | Source A in Decode 2 depends on an in-flight producer |
| predValA | output | DW | Guessed value for source A |
| predHitB | output | 1 | Source B in Decode 2 depends on an in-flight producer |
| predValB | output | DW | Guessed value for source B |
| flushReq | output | 1 | Full pipeline flush, one cycle |
| restartPc | output | PCW | Refetch address, valid with `flushReq` |

## Verification
An instruction offered at Fetch in cycle t sits in Decode 2 in cycle t+2. Its hit flags and guessed values are due then. It reaches Writeback in cycle t+9, and any flush it causes shows on `flushReq` and `restartPc` in cycle t+10. A branch offered in cycle t acts when `branchTaken` is driven in cycle t+7. The bench drives inputs on the falling edge and advances its queue-based model once per rising edge. It compares the registered and table outputs on the next falling edge, so every result is sampled in the cycle it becomes due. Directed sequences then count observed flushes and hits over each scenario against hand-derived totals.

// File: rtl/vp_pkg.sv
package vp_pkg;
  // Stage positions of the modelled pipeline (Fetch is the block input).
  localparam int NST   = 9;
  localparam int S_D1  = 0;
  localparam int S_D2  = 1;
  localparam int S_E1  = 2;
  localparam int S_E5  = 6;
  localparam int S_MEM = 7;
  localparam int S_WB  = 8;

  // Strobes from control to datapath.
  typedef struct packed {
    logic fullFlush;
    logic brFlush;
    logic allocA;
    logic allocB;
    logic wbWrite;
  } vp_strb_t;
endpackage

// File: rtl/vp_ctl.sv
module vp_ctl
  import vp_pkg::*;
#(
  parameter int PCW  = 32,
  parameter int RW   = 5,
  parameter int DW   = 32,
  parameter int SW   = 6,
  parameter int LOGN = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NST-1:0]  stV,
  input  logic [RW-1:0]   stDst [NST],
  input  logic [SW-1:0]   stSeq [NST],
  input  logic [RW-1:0]   d2SrcA,
  input  logic [RW-1:0]   d2SrcB,
  input  logic            branchTaken,
  input  logic [DW-1:0]   wbResult,
  input  logic [LOGN-1:0] lgV,
  input  logic [SW-1:0]   lgCSeq [LOGN],
  input  logic [SW-1:0]   lgPSeq [LOGN],
  input  logic [PCW-1:0]  lgCPc [LOGN],
  input  logic [DW-1:0]   lgVal [LOGN],
  output vp_strb_t        strb,
  output logic            hitA,
  output logic            hitB,
  output logic [SW-1:0]   prodSeqA,
  output logic [SW-1:0]   prodSeqB,
  output logic [LOGN-1:0] dropMask,
  output logic [PCW-1:0]  restartPcNext
);
  // Youngest older writer of src among Execute 1 .. Memory: {hit, seq}.
  function automatic logic [SW:0] findProd(input logic [RW-1:0] src);
    logic [SW:0] r;
    r = '0;
    for (int s = S_MEM; s >= S_E1; s--)
      if (stV[s] && src != '0 && stDst[s] == src) r = {1'b1, stSeq[s]};
    return r;
  endfunction

  logic [SW:0] resA, resB;
  assign resA     = findProd(d2SrcA);
  assign resB     = findProd(d2SrcB);
  assign hitA     = stV[S_D2] && resA[SW];
  assign hitB     = stV[S_D2] && resB[SW];
  assign prodSeqA = resA[SW-1:0];
  assign prodSeqB = resB[SW-1:0];

  logic            brTake, wbChk, found;
  logic [LOGN-1:0] younger, match, bad;
  logic [SW-1:0]   cAge, wOff, bestOff;

  always_comb begin
    brTake        = branchTaken && stV[S_E5];
    wbChk         = stV[S_WB] && stDst[S_WB] != '0;
    younger       = '0;
    match         = '0;
    bad           = '0;
    found         = 1'b0;
    bestOff       = '0;
    restartPcNext = '0;
    cAge          = '0;
    wOff          = '0;
    for (int l = 0; l < LOGN; l++) begin
      cAge       = lgCSeq[l] - stSeq[S_E5];
      younger[l] = brTake && lgV[l] && !cAge[SW-1] && cAge != '0;
      match[l]   = lgV[l] && !younger[l] && wbChk && lgPSeq[l] == stSeq[S_WB];
      bad[l]     = match[l] && lgVal[l] != wbResult;
      wOff       = lgCSeq[l] - stSeq[S_WB];
      if (bad[l] && (!found || wOff < bestOff)) begin
        found         = 1'b1;
        bestOff       = wOff;
        restartPcNext = lgCPc[l];
      end
    end
  end

  assign dropMask       = younger | match;
  assign strb.fullFlush = |bad;
  assign strb.brFlush   = brTake && !(|bad);
  assign strb.allocA    = hitA && !brTake && !(|bad);
  assign strb.allocB    = hitB && !brTake && !(|bad);
  assign strb.wbWrite   = wbChk;

  // R5: a flush can only come from a register-writing Writeback
  a_r5_flush_from_wb: assert property (@(posedge clk) disable iff (!rstN)
    strb.fullFlush |-> (stV[S_WB] && stDst[S_WB] != '0));
  // R8: register 0 never gets a logged guess
  a_r8_zero_no_dep: assert property (@(posedge clk) disable iff (!rstN)
    (strb.allocA |-> d2SrcA != '0) and (strb.allocB |-> d2SrcB != '0));
endmodule

// File: rtl/vp_dp.sv
module vp_dp
  import vp_pkg::*;
#(
  parameter int PCW  = 32,
  parameter int RW   = 5,
  parameter int DW   = 32,
  parameter int SW   = 6,
  parameter int LOGN = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchValid,
  input  logic [PCW-1:0]  fetchPc,
  input  logic [RW-1:0]   fetchDst,
  input  logic [RW-1:0]   fetchSrcA,
  input  logic [RW-1:0]   fetchSrcB,
  input  logic [DW-1:0]   wbResult,
  input  vp_strb_t        strb,
  input  logic [SW-1:0]   prodSeqA,
  input  logic [SW-1:0]   prodSeqB,
  input  logic [LOGN-1:0] dropMask,
  input  logic [PCW-1:0]  restartPcNext,
  output logic [NST-1:0]  stV,
  output logic [RW-1:0]   stDst [NST],
  output logic [SW-1:0]   stSeq [NST],
  output logic [RW-1:0]   d2SrcA,
  output logic [RW-1:0]   d2SrcB,
  output logic [LOGN-1:0] lgV,
  output logic [SW-1:0]   lgCSeq [LOGN],
  output logic [SW-1:0]   lgPSeq [LOGN],
  output logic [PCW-1:0]  lgCPc [LOGN],
  output logic [DW-1:0]   lgVal [LOGN],
  output logic [DW-1:0]   predValA,
  output logic [DW-1:0]   predValB,
  output logic            flushReq,
  output logic [PCW-1:0]  restartPc
);
  localparam int NREG = 1 << RW;
  localparam int LW   = (LOGN > 1) ? $clog2(LOGN) : 1;
  localparam int CW   = $clog2(LOGN + 1);

  logic [SW-1:0]  seqCnt;
  logic [PCW-1:0] d1Pc, d2Pc;
  logic [RW-1:0]  d1SrcA, d1SrcB;
  logic [DW-1:0]  lvt [NREG];

  // Stage valids, sequence counter, flush output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stV       <= '0;
      seqCnt    <= '0;
      flushReq  <= 1'b0;
      restartPc <= '0;
    end else begin
      flushReq <= strb.fullFlush;
      if (strb.fullFlush) restartPc <= restartPcNext;
      if (strb.fullFlush)    stV <= '0;
      else if (strb.brFlush) stV <= {stV[NST-2:S_E5], {(S_E5 + 1){1'b0}}};
      else                   stV <= {stV[NST-2:0], fetchValid};
      if (fetchValid && !strb.fullFlush && !strb.brFlush) seqCnt <= seqCnt + 1'b1;
    end
  end

  // Stage tags shift every cycle; validity decides their meaning
  always_ff @(posedge clk) begin
    stDst[S_D1] <= fetchDst;
    stSeq[S_D1] <= seqCnt;
    for (int i = 1; i < NST; i++) begin
      stDst[i] <= stDst[i-1];
      stSeq[i] <= stSeq[i-1];
    end
    d1Pc   <= fetchPc;
    d2Pc   <= d1Pc;
    d1SrcA <= fetchSrcA;
    d1SrcB <= fetchSrcB;
    d2SrcA <= d1SrcA;
    d2SrcB <= d1SrcB;
  end

  // Last-value table: read before this cycle's Writeback update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NREG; r++) lvt[r] <= '0;
    end else if (strb.wbWrite) begin
      lvt[stDst[S_WB]] <= wbResult;
    end
  end
  assign predValA = lvt[d2SrcA];
  assign predValB = lvt[d2SrcB];

  // Prediction log: two lowest free slots
  logic [LW-1:0]   slotA, slotB, slotForB;
  logic [CW-1:0]   freeCnt;
  logic [LOGN-1:0] setMask;

  always_comb begin
    slotA   = '0;
    slotB   = '0;
    freeCnt = '0;
    for (int l = LOGN - 1; l >= 0; l--) begin
      if (!lgV[l]) begin
        slotB   = slotA;
        slotA   = LW'(l);
        freeCnt = freeCnt + CW'(1);
      end
    end
    slotForB = strb.allocA ? slotB : slotA;
    setMask  = '0;
    if (strb.allocA) setMask[slotA] = 1'b1;
    if (strb.allocB) setMask[slotForB] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lgV <= '0;
    else if (strb.fullFlush) lgV <= '0;
    else                     lgV <= (lgV & ~dropMask) | setMask;
  end

  always_ff @(posedge clk) begin
    if (strb.allocA) begin
      lgCSeq[slotA] <= stSeq[S_D2];
      lgCPc[slotA]  <= d2Pc;
      lgPSeq[slotA] <= prodSeqA;
      lgVal[slotA]  <= predValA;
    end
    if (strb.allocB) begin
      lgCSeq[slotForB] <= stSeq[S_D2];
      lgCPc[slotForB]  <= d2Pc;
      lgPSeq[slotForB] <= prodSeqB;
      lgVal[slotForB]  <= predValB;
    end
  end

  // R5: a flush empties every stage and the log, and raises flushReq
  a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.fullFlush |=> (stV == '0 && lgV == '0 && flushReq));
  // R7: a taken branch leaves nothing from Fetch to Execute 4 behind it
  a_r7_branch_squash: assert property (@(posedge clk) disable iff (!rstN)
    strb.brFlush |=> (stV[S_E5:0] == '0));
  // R9: the log always has room for the guesses made in one cycle
  a_r9_log_room: assert property (@(posedge clk) disable iff (!rstN)
    (strb.allocA || strb.allocB) |-> freeCnt >= CW'(strb.allocA) + CW'(strb.allocB));
endmodule

// File: rtl/vp_resolver.sv
module vp_resolver
  import vp_pkg::*;
#(
  parameter int PCW  = 32,
  parameter int RW   = 5,
  parameter int DW   = 32,
  parameter int SW   = 6,
  parameter int LOGN = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           fetchValid,
  input  logic [PCW-1:0] fetchPc,
  input  logic [RW-1:0]  fetchDst,
  input  logic [RW-1:0]  fetchSrcA,
  input  logic [RW-1:0]  fetchSrcB,
  input  logic           branchTaken,
  input  logic [DW-1:0]  wbResult,
  output logic           predHitA,
  output logic [DW-1:0]  predValA,
  output logic           predHitB,
  output logic [DW-1:0]  predValB,
  output logic           flushReq,
  output logic [PCW-1:0] restartPc
);
  vp_strb_t        strb;
  logic [NST-1:0]  stV;
  logic [RW-1:0]   stDst [NST];
  logic [SW-1:0]   stSeq [NST];
  logic [RW-1:0]   d2SrcA, d2SrcB;
  logic [LOGN-1:0] lgV, dropMask;
  logic [SW-1:0]   lgCSeq [LOGN];
  logic [SW-1:0]   lgPSeq [LOGN];
  logic [PCW-1:0]  lgCPc [LOGN];
  logic [DW-1:0]   lgVal [LOGN];
  logic [SW-1:0]   prodSeqA, prodSeqB;
  logic [PCW-1:0]  restartPcNext;

  vp_ctl #(.PCW(PCW), .RW(RW), .DW(DW), .SW(SW), .LOGN(LOGN)) i_ctl (
    .clk(clk), .rstN(rstN), .stV(stV), .stDst(stDst), .stSeq(stSeq),
    .d2SrcA(d2SrcA), .d2SrcB(d2SrcB), .branchTaken(branchTaken),
    .wbResult(wbResult), .lgV(lgV), .lgCSeq(lgCSeq), .lgPSeq(lgPSeq),
    .lgCPc(lgCPc), .lgVal(lgVal), .strb(strb), .hitA(predHitA), .hitB(predHitB),
    .prodSeqA(prodSeqA), .prodSeqB(prodSeqB), .dropMask(dropMask),
    .restartPcNext(restartPcNext)
  );

  vp_dp #(.PCW(PCW), .RW(RW), .DW(DW), .SW(SW), .LOGN(LOGN)) i_dp (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .fetchDst(fetchDst), .fetchSrcA(fetchSrcA), .fetchSrcB(fetchSrcB),
    .wbResult(wbResult), .strb(strb), .prodSeqA(prodSeqA), .prodSeqB(prodSeqB),
    .dropMask(dropMask), .restartPcNext(restartPcNext), .stV(stV),
    .stDst(stDst), .stSeq(stSeq), .d2SrcA(d2SrcA), .d2SrcB(d2SrcB),
    .lgV(lgV), .lgCSeq(lgCSeq), .lgPSeq(lgPSeq), .lgCPc(lgCPc), .lgVal(lgVal),
    .predValA(predValA), .predValB(predValB), .flushReq(flushReq),
    .restartPc(restartPc)
  );
endmodule

// File: tb/test_vp_resolver.sv
`timescale 1ns/1ps
module test_vp_resolver;
  localparam int PCW = 32, RW = 5, DW = 32, SW = 6, LOGN = 16;

  logic           clk = 1'b0;
  logic           rstN;
  logic           fetchValid;
  logic [PCW-1:0] fetchPc;
  logic [RW-1:0]  fetchDst, fetchSrcA, fetchSrcB;
  logic           branchTaken;
  logic [DW-1:0]  wbResult;
  logic           predHitA, predHitB, flushReq;
  logic [DW-1:0]  predValA, predValB;
  logic [PCW-1:0] restartPc;

  always #4 clk = ~clk;

  vp_resolver #(.PCW(PCW), .RW(RW), .DW(DW), .SW(SW), .LOGN(LOGN)) i_vp_resolver (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .fetchDst(fetchDst), .fetchSrcA(fetchSrcA), .fetchSrcB(fetchSrcB),
    .branchTaken(branchTaken), .wbResult(wbResult), .predHitA(predHitA),
    .predValA(predValA), .predHitB(predHitB), .predValB(predValB),
    .flushReq(flushReq), .restartPc(restartPc)
  );

  // Behavioural model: in-flight instructions and logged guesses as queues
  typedef struct { int pc; int dst; int sa; int sb; int seq; int val; int stg; } mins_t;
  typedef struct { int cseq; int cpc; int pseq; int pval; } mlog_t;
  mins_t pipe[$];
  mlog_t mlog[$];
  int    lvtM [32];
  bit    expFlush;
  int    expRestart, seqM, pcNext;
  int    nChk, nFail, flushSeen, hitSeen, lastRestart;
  bit    done;

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int prodOf(int src);
    int best = -1, bestStg = 99;
    if (src == 0) return -1;
    foreach (pipe[i])
      if (pipe[i].stg >= 2 && pipe[i].stg <= 7 && pipe[i].dst == src && pipe[i].stg < bestStg) begin
        bestStg = pipe[i].stg;
        best    = pipe[i].seq;
      end
    return best;
  endfunction

  function automatic int findStg(int s);
    foreach (pipe[i]) if (pipe[i].stg == s) return i;
    return -1;
  endfunction

  task automatic mstep(bit fv, int pc, int dst, int sa, int sb, int val, bit br, int wbres);
    int wbI = findStg(8), e5I = findStg(6), d2I = findStg(1);
    bit brT = br && e5I >= 0;
    int brSeq = brT ? pipe[e5I].seq : 0;
    bit mis = 0;
    int bestSeq = 0, rpc = 0, p;
    mlog_t keep[$];
    mins_t nxt[$];
    foreach (mlog[j]) begin
      if (brT && mlog[j].cseq > brSeq) continue;
      if (wbI >= 0 && pipe[wbI].dst != 0 && mlog[j].pseq == pipe[wbI].seq) begin
        if (mlog[j].pval != wbres && (!mis || mlog[j].cseq < bestSeq)) begin
          mis = 1; bestSeq = mlog[j].cseq; rpc = mlog[j].cpc;
        end
        continue;
      end
      keep.push_back(mlog[j]);
    end
    if (d2I >= 0 && !brT && !mis) begin
      p = prodOf(pipe[d2I].sa);
      if (p >= 0) keep.push_back('{pipe[d2I].seq, pipe[d2I].pc, p, lvtM[pipe[d2I].sa]});
      p = prodOf(pipe[d2I].sb);
      if (p >= 0) keep.push_back('{pipe[d2I].seq, pipe[d2I].pc, p, lvtM[pipe[d2I].sb]});
    end
    if (wbI >= 0 && pipe[wbI].dst != 0) lvtM[pipe[wbI].dst] = wbres;
    expFlush = mis;
    if (mis) begin
      expRestart = rpc;
      pipe.delete();
      mlog.delete();
    end else begin
      mlog = keep;
      foreach (pipe[i]) begin
        mins_t m = pipe[i];
        if (m.stg == 8) continue;
        if (brT && m.stg <= 5) continue;
        m.stg++;
        nxt.push_back(m);
      end
      if (fv && !brT) begin
        nxt.push_back('{pc, dst, sa, sb, seqM, val, 0});
        seqM++;
      end
      pipe = nxt;
    end
  endtask

  task automatic tick(bit fv, int dst, int sa, int sb, int val, bit br);
    int wv = 0, w = findStg(8), d2;
    int pcUsed = pcNext;
    if (w >= 0) wv = pipe[w].val;
    fetchValid = fv; fetchPc = PCW'(pcUsed); fetchDst = RW'(dst);
    fetchSrcA = RW'(sa); fetchSrcB = RW'(sb); branchTaken = br; wbResult = DW'(wv);
    @(posedge clk);
    @(negedge clk);
    mstep(fv, pcUsed, dst, sa, sb, val, br, wv);
    if (expFlush) pcNext = expRestart;
    else if (fv) pcNext = pcNext + 4;
    d2 = findStg(1);
    chk(predHitA == (d2 >= 0 && prodOf(pipe[d2].sa) >= 0), "R2 hitA", predHitA, !predHitA);
    chk(predHitB == (d2 >= 0 && prodOf(pipe[d2].sb) >= 0), "R2 hitB", predHitB, !predHitB);
    if (d2 >= 0) begin
      chk(int'(predValA) == lvtM[pipe[d2].sa], "R3 valA", int'(predValA), lvtM[pipe[d2].sa]);
      chk(int'(predValB) == lvtM[pipe[d2].sb], "R3 valB", int'(predValB), lvtM[pipe[d2].sb]);
    end
    chk(flushReq == expFlush, "R5 flush", flushReq, expFlush);
    if (expFlush) chk(int'(restartPc) == expRestart, "R6 restart", int'(restartPc), expRestart);
    if (flushReq) begin flushSeen++; lastRestart = int'(restartPc); end
    hitSeen += int'(predHitA) + int'(predHitB);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick(0, 0, 0, 0, 0, 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
    end
  end

  initial begin
    int f0, h0, pc1;
    nChk = 0; nFail = 0; flushSeen = 0; hitSeen = 0; done = 0;
    seqM = 0; pcNext = 'h100; expFlush = 0; expRestart = 0; lastRestart = 0;
    foreach (lvtM[r]) lvtM[r] = 0;
    rstN = 0; fetchValid = 0; fetchPc = '0; fetchDst = '0; fetchSrcA = '0;
    fetchSrcB = '0; branchTaken = 0; wbResult = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    chk(flushReq == 0, "R1 flush", flushReq, 0);
    chk(predHitA == 0 && predHitB == 0, "R1 hits", predHitA | predHitB, 0);

    // Independent instructions: no hits
    h0 = hitSeen;
    for (int k = 1; k <= 4; k++) tick(1, k, 0, 0, k, 0);
    idle(12);
    chk(hitSeen == h0, "R2 independent", hitSeen - h0, 0);

    // R9: two guesses for r3 in one instruction plus one more, all correct
    f0 = flushSeen; h0 = hitSeen;
    tick(1, 3, 0, 0, 4, 0);   // r3 <- 4 (table r3 was 3 from above)
    idle(12);
    tick(1, 3, 0, 0, 4, 0);   // writes 4 again, guess 4 is right
    tick(1, 9, 3, 3, 1, 0);
    tick(1, 10, 3, 0, 1, 0);
    idle(12);
    chk(flushSeen == f0, "R9 no flush", flushSeen - f0, 0);
    chk(hitSeen - h0 == 3, "R9 guesses", hitSeen - h0, 3);

    // R6: two wrong consumers of r5, oldest PC restarts
    f0 = flushSeen;
    tick(1, 5, 0, 0, 7, 0);   // table r5 is 0, real 7
    pc1 = pcNext;
    tick(1, 11, 5, 0, 0, 0);
    tick(1, 12, 0, 5, 0, 0);
    idle(12);
    chk(flushSeen - f0 == 1, "R5 one flush", flushSeen - f0, 1);
    chk(lastRestart == pc1, "R6 oldest", lastRestart, pc1);
    // R10: the flushing Writeback still updated r5
    tick(1, 0, 5, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0);
    chk(int'(predValA) == 7, "R10 table", int'(predValA), 7);
    idle(12);

    // R4: nearest writer of r6 is wrong, older one right -> flush
    f0 = flushSeen;
    tick(1, 6, 0, 0, 0, 0);
    tick(1, 6, 0, 0, 9, 0);
    pc1 = pcNext;
    tick(1, 13, 6, 0, 0, 0);
    idle(12);
    chk(flushSeen - f0 == 1, "R4 nearest", flushSeen - f0, 1);
    chk(lastRestart == pc1, "R4 restart", lastRestart, pc1);

    // R7: wrong guess of a consumer younger than a taken branch is dropped
    f0 = flushSeen;
    tick(1, 7, 0, 0, 11, 0);
    tick(1, 0, 0, 0, 0, 0);   // branch
    tick(1, 14, 7, 0, 0, 0);  // consumer, guess 0 is wrong
    idle(5);
    tick(1, 0, 0, 0, 0, 1);   // branch in Execute 5 now
    idle(12);
    chk(flushSeen == f0, "R7 dropped", flushSeen - f0, 0);

    // R8: register 0 as destination and as source
    h0 = hitSeen;
    tick(1, 0, 0, 0, 5, 0);
    tick(1, 15, 0, 0, 0, 0);
    idle(12);
    chk(hitSeen == h0, "R8 zero", hitSeen - h0, 0);

    // Mixed random traffic
    for (int k = 0; k < 3000; k++)
      tick(($urandom % 5) != 0, $urandom % 8, $urandom % 8, $urandom % 8,
           $urandom % 3, ($urandom % 20) == 0);
    idle(12);
    done = 1;
    report();
  end
endmodule